// File: doc/BRIEF.md
# High-Speed Infrared Frame Transmit Controller

This block sits between the transmit byte queue of a high-speed infrared port and the serial framer that adds flags, CRC and line coding. Software or a DMA engine pushes bytes into an internal tagged queue. The controller hands those bytes to the framer one per accepted cycle and marks the last byte of each frame. The framer then appends the CRC and closes the frame.

There are three ways to end a frame. Software can arm an end marker that tags its next programmed-I/O byte. The DMA engine can raise terminal count together with a byte. A programmable length counter can close a frame after a fixed number of bytes, which cuts a long block into equal frames that follow one another directly. A selectable stop mode pauses the controller after every frame and raises an interrupt. Software resumes it by clearing the halted status.

When the framer asks for a byte mid-frame and the queue is empty, the controller requests an abort with an inverted CRC. It then silently discards the rest of that frame from the queue. It reports the under-run only when that frame's end is found, and it sends nothing more until software clears the under-run status.

Top module: `hsir_tx_ctrl`

## Requirements
- R1: While the controller is idle, not halted and with no under-run pending, a byte written at clock edge k is presented on `fr_valid`/`fr_data` from the cycle after edge k+1. No byte is presented before that.
- R2: A pulse on `eot_set` arms an end marker. The next write with `wr_dma`=0 stores its byte tagged as end of frame and disarms the marker, so later programmed-I/O bytes are untagged.
- R3: A tagged byte is presented with `fr_eof`=1. Once the framer accepts it, `fr_valid` is 0 in the next cycle and the next frame starts from idle.
- R4: A write with `wr_dma`=1 and `wr_tc`=1 stores its byte tagged as end of frame. A DMA write with `wr_tc`=0 is untagged.
- R5: At each frame start the length counter loads `len_cfg`. Each counted byte the framer accepts decrements it, and the counted byte that brings it to zero carries `fr_eof`=1. A `len_cfg` of 0 disables the counter.
- R6: With `len_on_dma`=1 only bytes written with `wr_dma`=1 are counted. With `len_on_dma`=0 only bytes written with `wr_dma`=0 are counted. Uncounted bytes never end a frame through the counter.
- R7: With `stop_mode`=1, `halted` becomes 1 after the framer accepts the last byte of a frame, and no byte is presented while it is 1. A pulse on `halt_clr` clears it in the next cycle and transmission resumes.
- R8: If `fr_ready`=1 during a frame while the queue is empty, `fr_abort` is 1 for exactly that cycle, with `fr_valid`=0.
- R9: After an abort, the remaining bytes of the frame are removed from the queue without being presented, up to the end of the frame. `urun_flag` then becomes 1 and no byte is presented until a pulse on `urun_clr` clears it.
- R10: `irq` is 1 exactly while `halted` or `urun_flag` is 1, and it stays 1 until the flag that caused it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to write |
| wr_dma | input | 1 | 1: write comes from DMA, 0: programmed I/O |
| wr_tc | input | 1 | DMA terminal count, qualifies a DMA write |
| eot_set | input | 1 | Arm the end marker for the next programmed-I/O byte |
| len_cfg | input | 12 | Frame length in bytes, 0 disables the counter |
| len_on_dma | input | 1 | 1: counter applies to DMA bytes, 0: to programmed-I/O bytes |
| stop_mode | input | 1 | Halt after every frame |
| halt_clr | input | 1 | Clear the halted status |
| urun_clr | input | 1 | Clear the under-run status |
| fr_ready | input | 1 | Framer requests a byte this cycle |
| fr_valid | output | 1 | Byte presented to the framer |
| fr_data | output | 8 | Presented byte |
| fr_eof | output | 1 | Presented byte is the last of its frame |
| fr_abort | output | 1 | Close the frame with an inverted CRC |
| halted | output | 1 | Stopped after a frame in stop mode |
| urun_flag | output | 1 | Under-run reported |
| irq | output | 1 | Interrupt request |

## Verification
A written byte is due at the framer two edges after its write edge: one edge fills the queue and one moves the controller from idle to sending. The bench therefore checks the timing of R1 at exactly the first and second falling edges after the write. The framer outputs are combinational from registered state and the current `fr_ready`, so every byte, end mark and abort is logged 2 ns after the falling edge at which it is presented, and it is compared later against an expected list that bench functions compute. Status flags settle one edge after the frame end, a clear pulse or a halt, so they are read only after enough idle cycles have passed for the whole batch to drain.

// File: rtl/hsir_tx_pkg.sv
package hsir_tx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_DRAIN = 2'd2
  } tx_state_e;

  typedef struct packed {
    logic              dma;
    logic              tag;
    logic [BYTE_W-1:0] data;
  } q_entry_t;
endpackage

// File: rtl/hsir_tag_fifo.sv
module hsir_tag_fifo
  import hsir_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  q_entry_t push_ent,
  input  logic     pop,
  output q_entry_t head,
  output logic     empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  q_entry_t         mem [DEPTH];
  logic [PTR_W-1:0] wptr, wptr_n, rptr, rptr_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign do_push = push && (cnt != FULL_CNT);
  assign do_pop  = pop && !empty;
  assign head    = mem[rptr];

  always_comb begin
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = cnt;
    if (do_push) wptr_n = (wptr == LAST_PTR) ? '0 : wptr + PTR_W'(1);
    if (do_pop)  rptr_n = (rptr == LAST_PTR) ? '0 : rptr + PTR_W'(1);
    if (do_push && !do_pop) cnt_n = cnt + CNT_W'(1);
    else if (do_pop && !do_push) cnt_n = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      cnt  <= cnt_n;
    end
  end
endmodule

// File: rtl/hsir_len_counter.sv
module hsir_len_counter #(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             step,
  output logic             at_last
);
  logic [LEN_W-1:0] cnt, cnt_n;

  assign at_last = (cnt == LEN_W'(1));

  always_comb begin
    cnt_n = cnt;
    if (load) cnt_n = load_val;
    else if (step && (cnt != '0)) cnt_n = cnt - LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/hsir_tx_seq.sv
module hsir_tx_seq
  import hsir_tx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     empty,
  input  q_entry_t head,
  input  logic     fr_ready,
  input  logic     len_on_dma,
  input  logic     cnt_last,
  input  logic     halted,
  input  logic     urun_flag,
  output logic     pop,
  output logic     cnt_load,
  output logic     cnt_step,
  output logic     fr_valid,
  output logic     fr_eof,
  output logic     fr_abort,
  output logic     frame_ok,
  output logic     drain_end
);
  tx_state_e state, state_n;
  logic      counted, byte_end;

  assign counted  = (head.dma == len_on_dma);
  assign byte_end = head.tag || (cnt_last && counted);

  always_comb begin
    state_n   = state;
    pop       = 1'b0;
    cnt_load  = 1'b0;
    fr_valid  = 1'b0;
    fr_eof    = 1'b0;
    fr_abort  = 1'b0;
    frame_ok  = 1'b0;
    drain_end = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!empty && !halted && !urun_flag) begin
          cnt_load = 1'b1;
          state_n  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (!empty) begin
          fr_valid = 1'b1;
          fr_eof   = byte_end;
          if (fr_ready) begin
            pop = 1'b1;
            if (byte_end) begin
              frame_ok = 1'b1;
              state_n  = ST_IDLE;
            end
          end
        end else if (fr_ready) begin
          fr_abort = 1'b1;
          state_n  = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!empty) begin
          pop = 1'b1;
          if (byte_end) begin
            drain_end = 1'b1;
            state_n   = ST_IDLE;
          end
        end
      end
      default: state_n = ST_IDLE;
    endcase
    cnt_step = pop && counted;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end
endmodule

// File: rtl/hsir_tx_ctrl.sv
module hsir_tx_ctrl
  import hsir_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_dma,
  input  logic              wr_tc,
  input  logic              eot_set,
  input  logic [LEN_W-1:0]  len_cfg,
  input  logic              len_on_dma,
  input  logic              stop_mode,
  input  logic              halt_clr,
  input  logic              urun_clr,
  input  logic              fr_ready,
  output logic              fr_valid,
  output logic [BYTE_W-1:0] fr_data,
  output logic              fr_eof,
  output logic              fr_abort,
  output logic              halted,
  output logic              urun_flag,
  output logic              irq
);
  logic     eot_armed, eot_armed_n, halted_n, urun_n;
  q_entry_t wr_ent, head;
  logic     empty, pop, cnt_load, cnt_step, cnt_last, frame_ok, drain_end;

  // End tag: terminal count for DMA writes, armed marker for PIO writes
  always_comb begin
    wr_ent.data = wr_data;
    wr_ent.dma  = wr_dma;
    wr_ent.tag  = wr_dma ? wr_tc : eot_armed;
  end

  always_comb begin
    eot_armed_n = eot_armed;
    if (eot_set) eot_armed_n = 1'b1;
    else if (wr_en && !wr_dma) eot_armed_n = 1'b0;

    halted_n = halted;
    if (frame_ok && stop_mode) halted_n = 1'b1;
    else if (halt_clr) halted_n = 1'b0;

    urun_n = urun_flag;
    if (drain_end) urun_n = 1'b1;
    else if (urun_clr) urun_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eot_armed <= 1'b0;
      halted    <= 1'b0;
      urun_flag <= 1'b0;
    end else begin
      eot_armed <= eot_armed_n;
      halted    <= halted_n;
      urun_flag <= urun_n;
    end
  end

  assign irq     = halted | urun_flag;
  assign fr_data = head.data;

  hsir_tag_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (wr_en),
    .push_ent (wr_ent),
    .pop      (pop),
    .head     (head),
    .empty    (empty)
  );

  hsir_len_counter #(.LEN_W(LEN_W)) u_len (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (len_cfg),
    .step     (cnt_step),
    .at_last  (cnt_last)
  );

  hsir_tx_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .empty      (empty),
    .head       (head),
    .fr_ready   (fr_ready),
    .len_on_dma (len_on_dma),
    .cnt_last   (cnt_last),
    .halted     (halted),
    .urun_flag  (urun_flag),
    .pop        (pop),
    .cnt_load   (cnt_load),
    .cnt_step   (cnt_step),
    .fr_valid   (fr_valid),
    .fr_eof     (fr_eof),
    .fr_abort   (fr_abort),
    .frame_ok   (frame_ok),
    .drain_end  (drain_end)
  );
endmodule

// File: rtl/hsir_tx_ctrl_chk.sv
module hsir_tx_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic fr_ready,
  input logic fr_valid,
  input logic fr_eof,
  input logic fr_abort,
  input logic halted,
  input logic urun_flag,
  input logic irq,
  input logic halt_clr,
  input logic urun_clr
);
  a_r3_eof_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_eof && fr_ready) |=> !fr_valid);

  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !fr_valid);

  a_r7_halt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    halt_clr |=> !halted);

  a_r8_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fr_abort |=> !fr_abort);

  a_r9_urun_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    urun_flag |-> !fr_valid);

  a_r9_urun_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_clr && urun_flag) |=> !urun_flag);

  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !halt_clr && !urun_clr) |=> irq);
endmodule

bind hsir_tx_ctrl hsir_tx_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fr_ready  (fr_ready),
  .fr_valid  (fr_valid),
  .fr_eof    (fr_eof),
  .fr_abort  (fr_abort),
  .halted    (halted),
  .urun_flag (urun_flag),
  .irq       (irq),
  .halt_clr  (halt_clr),
  .urun_clr  (urun_clr)
);

// File: tb/hsir_tx_ctrl_test.sv
module hsir_tx_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, wr_dma, wr_tc, eot_set;
  logic [7:0]  wr_data;
  logic [11:0] len_cfg;
  logic        len_on_dma, stop_mode, halt_clr, urun_clr, fr_ready;
  logic        fr_valid, fr_eof, fr_abort, halted, urun_flag, irq;
  logic [7:0]  fr_data;

  int checks = 0;
  int fails  = 0;
  int aborts = 0;
  logic [7:0] got_d[$];
  bit         got_e[$];
  logic [7:0] exp_d[$];
  bit         exp_e[$];

  always #10 clk = ~clk;

  hsir_tx_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_dma(wr_dma), .wr_tc(wr_tc), .eot_set(eot_set), .len_cfg(len_cfg),
    .len_on_dma(len_on_dma), .stop_mode(stop_mode), .halt_clr(halt_clr),
    .urun_clr(urun_clr), .fr_ready(fr_ready), .fr_valid(fr_valid),
    .fr_data(fr_data), .fr_eof(fr_eof), .fr_abort(fr_abort),
    .halted(halted), .urun_flag(urun_flag), .irq(irq)
  );

  // Framer-side log, taken away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (fr_valid && fr_ready) begin
        got_d.push_back(fr_data);
        got_e.push_back(fr_eof);
      end
      if (fr_abort) aborts++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pio_wr(input logic [7:0] d, input bit last);
    if (last) begin
      @(negedge clk);
      eot_set = 1'b1;
    end
    @(negedge clk);
    eot_set = 1'b0; wr_en = 1'b1; wr_dma = 1'b0; wr_tc = 1'b0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic dma_wr(input logic [7:0] d, input bit tc);
    @(negedge clk);
    wr_en = 1'b1; wr_dma = 1'b1; wr_tc = tc; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_tc = 1'b0;
  endtask

  // Expected end mark of byte i (1-based) in a batch of n same-source bytes
  function automatic bit exp_eof(input int i, input int n, input bit is_dma,
                                 input bit cnt_dma, input int len);
    int since = 0;
    bit e = 1'b0;
    for (int k = 1; k <= i; k++) begin
      e = (k == n);
      if ((is_dma == cnt_dma) && (len != 0)) begin
        since++;
        if (since == len) e = 1'b1;
      end
      if (e) since = 0;
    end
    return e;
  endfunction

  task automatic compare(input string req);
    check(got_d.size() == exp_d.size(), {req, " byte count"}, got_d.size(), exp_d.size());
    for (int i = 0; i < exp_d.size() && i < got_d.size(); i++) begin
      check(got_d[i] == exp_d[i], {req, " data"}, got_d[i], exp_d[i]);
      check(got_e[i] == exp_e[i], {req, " eof"}, got_e[i], exp_e[i]);
    end
  endtask

  task automatic clear_logs();
    got_d.delete(); got_e.delete(); exp_d.delete(); exp_e.delete();
  endtask

  task automatic run_batch(input int n, input bit is_dma, input bit cnt_dma,
                           input int len, input string req);
    logic [7:0] d;
    fr_ready = 1'b0;
    len_cfg = 12'(len);
    len_on_dma = cnt_dma;
    clear_logs();
    for (int i = 1; i <= n; i++) begin
      d = 8'($urandom);
      exp_d.push_back(d);
      exp_e.push_back(exp_eof(i, n, is_dma, cnt_dma, len));
      if (is_dma) dma_wr(d, i == n);
      else pio_wr(d, i == n);
    end
    @(negedge clk);
    fr_ready = 1'b1;
    wait_cyc(3 * n + 6);
    fr_ready = 1'b0;
    compare(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ab0;
    logic [7:0] d0;
    void'($urandom(32'd2024));
    rst_n = 1'b0; wr_en = 1'b0; wr_dma = 1'b0; wr_tc = 1'b0; eot_set = 1'b0;
    wr_data = '0; len_cfg = '0; len_on_dma = 1'b0; stop_mode = 1'b0;
    halt_clr = 1'b0; urun_clr = 1'b0; fr_ready = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    #2;
    check(!fr_valid && !fr_abort && !fr_eof, "reset outputs", fr_valid, 0);
    check(!halted && !urun_flag && !irq, "R10 reset irq", irq, 0);

    // R1: first byte due two edges after its write edge
    clear_logs();
    d0 = 8'($urandom);
    @(negedge clk);
    wr_en = 1'b1; wr_dma = 1'b0; wr_data = d0;
    @(negedge clk);
    wr_en = 1'b0;
    #2;
    check(fr_valid == 1'b0, "R1 not yet presented", fr_valid, 0);
    @(negedge clk);
    #2;
    check(fr_valid == 1'b1, "R1 presented", fr_valid, 1);
    check(fr_data == d0, "R1 data", fr_data, d0);
    exp_d.push_back(d0); exp_e.push_back(1'b0);
    // R2: armed marker tags only the next PIO byte
    @(negedge clk);
    eot_set = 1'b1;
    @(negedge clk);
    eot_set = 1'b0;
    for (int i = 0; i < 3; i++) begin
      d0 = 8'($urandom);
      exp_d.push_back(d0);
      exp_e.push_back(i != 1);
      pio_wr(d0, i == 2);
    end
    fr_ready = 1'b1;
    wait_cyc(12);
    fr_ready = 1'b0;
    compare("R2");
    check(aborts == 0, "R3 no abort on clean frames", aborts, 0);

    // R3, R4: DMA terminal count
    run_batch(3, 1'b1, 1'b0, 0, "R4");
    // R5: length counter splits PIO block
    run_batch(7, 1'b0, 1'b0, 3, "R5");
    // R6: counter on DMA ignores PIO bytes, then counts DMA ones
    run_batch(5, 1'b0, 1'b1, 3, "R6 pio uncounted");
    run_batch(4, 1'b1, 1'b1, 3, "R6 dma counted");
    // R5: zero length disables
    run_batch(5, 1'b0, 1'b0, 0, "R5 zero length");

    // R7, R10: stop after each frame
    stop_mode = 1'b1; len_cfg = '0;
    clear_logs();
    for (int i = 0; i < 4; i++) begin
      d0 = 8'($urandom);
      exp_d.push_back(d0);
      exp_e.push_back(i == 1 || i == 3);
      pio_wr(d0, i == 1 || i == 3);
    end
    fr_ready = 1'b1;
    wait_cyc(10);
    check(got_d.size() == 2, "R7 halt after frame", got_d.size(), 2);
    check(halted == 1'b1, "R7 halted set", halted, 1);
    wait_cyc(5);
    check(got_d.size() == 2, "R7 stays halted", got_d.size(), 2);
    check(irq == 1'b1, "R10 irq held", irq, 1);
    halt_clr = 1'b1;
    @(negedge clk);
    halt_clr = 1'b0;
    wait_cyc(8);
    compare("R7 resume");
    check(halted == 1'b1, "R7 halted again", halted, 1);
    halt_clr = 1'b1;
    @(negedge clk);
    halt_clr = 1'b0;
    stop_mode = 1'b0;
    #2;
    check(!halted && !irq, "R10 irq cleared", irq, 0);

    // R8, R9: under-run
    fr_ready = 1'b0;
    clear_logs();
    ab0 = aborts;
    for (int i = 0; i < 2; i++) begin
      d0 = 8'($urandom);
      exp_d.push_back(d0); exp_e.push_back(1'b0);
      pio_wr(d0, 1'b0);
    end
    wait_cyc(2);
    fr_ready = 1'b1;
    wait_cyc(6);
    compare("R8 sent before under-run");
    check(aborts == ab0 + 1, "R8 single abort", aborts - ab0, 1);
    check(urun_flag == 1'b0, "R9 not reported before frame end", urun_flag, 0);
    for (int i = 0; i < 3; i++) pio_wr(8'($urandom), i == 2);
    wait_cyc(3);
    check(got_d.size() == 2, "R9 drained bytes hidden", got_d.size(), 2);
    check(urun_flag == 1'b1, "R9 reported at frame end", urun_flag, 1);
    check(irq == 1'b1, "R10 irq on under-run", irq, 1);
    for (int i = 0; i < 2; i++) begin
      d0 = 8'($urandom);
      exp_d.push_back(d0); exp_e.push_back(i == 1);
      pio_wr(d0, i == 1);
    end
    wait_cyc(6);
    check(got_d.size() == 2, "R9 stopped until cleared", got_d.size(), 2);
    urun_clr = 1'b1;
    @(negedge clk);
    urun_clr = 1'b0;
    wait_cyc(8);
    compare("R9 resume");
    check(!urun_flag && !irq, "R10 irq after clear", irq, 0);
    check(aborts == ab0 + 1, "R8 no further abort", aborts - ab0, 1);
    fr_ready = 1'b0;

    // Random batches
    for (int b = 0; b < 8; b++) begin
      run_batch(1 + int'($urandom % 12), 1'($urandom), 1'($urandom),
                int'($urandom % 5), "R5 R6 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule